// File: doc/BRIEF.md
# Dual Down-Counting Timer with Interrupt Combine

This block sits on a byte-wide CPU bus and provides two 16-bit down-counters. Each counter has a 16-bit reload latch. The block also holds a small interrupt flag register, a matching enable register and a single interrupt output, which is the OR of every enabled pending source.

Timer A decrements on its own tick strobe. A mode bit in the control register selects one-shot or periodic operation. In periodic mode the counter reloads from its latch at every expiry. Timer B decrements on a separate tick strobe and is always one-shot. Software stages the low byte of timer B's latch first. Writing the high byte then loads the counter and re-arms the timer in a single access. Reading timer B's low count byte acknowledges its interrupt.

A third flag source is set by a one-cycle event pulse from a neighbouring serial shifter. Software reads the flag register to poll the sources. It clears flags by writing ones to that register or by the per-timer acknowledge reads.

Top module: `pdt_top`

## Requirements
- R1: After reset the timer A count and both latches are 0xFFFF, the flag register reads 0x00, the enable register reads 0x80 and `irq` is low.
- R2: A write to address 4 replaces bits 7:0 of timer B's latch only. The timer B count does not change.
- R3: A write to address 5 sets latch bits 15:8 and loads the whole latch into the timer B count in the same cycle. It also clears flag bit 5 and re-arms timer B. A timer B tick in that same cycle is overridden: there is no decrement and no flag.
- R4: The timer B count decrements once per cycle with `t2Tick` high and ignores `t1Tick`. A tick taken while the armed count is zero sets flag bit 5, and the count wraps to 0xFFFF.
- R5: After its expiry, timer B keeps counting but sets no further flag until the next address-5 write. This holds whatever the control register (address 6) holds.
- R6: A read of address 4 returns count bits 7:0 and clears flag bit 5. `irq` follows at the same edge. A read of address 5 returns count bits 15:8 and leaves the flag alone.
- R7: With control bit 6 clear, timer A is one-shot. A write to address 1 loads it from the latch, and the latch low byte is written at address 0 or 2. It sets flag bit 6 once and then wraps to 0xFFFF without flagging again. A read of address 0 returns count bits 7:0 and clears flag bit 6.
- R8: With control bit 6 set, timer A reloads from its latch on the expiring tick. It sets flag bit 6 every latch+1 ticks.
- R9: Flag register at address 7: bit 6 timer A, bit 5 timer B, bit 2 shifter event. Bit 7 reads as the `irq` level. Writing ones clears the matching flags.
- R10: Enable register at address 8. A write with bit 7 set sets the enables written as one. A write with bit 7 clear clears them. Bit 7 reads as 1.
- R11: `irq` is high exactly when some bit among 6, 5 and 2 is both flagged and enabled.
- R12: When a flag-setting event and a flag clear (an acknowledge read or a flag-register write) hit the same bit in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | 8 | Write byte |
| busRdata | output | 8 | Read byte for the addressed register (combinational) |
| t1Tick | input | 1 | Timer A decrement enable |
| t2Tick | input | 1 | Timer B decrement enable |
| shiftEvent | input | 1 | One-cycle pulse that sets flag bit 2 |
| irq | output | 1 | Combined interrupt request |

## Verification
Two collisions can share a cycle: a flag being set while software clears it, and a timer B reload arriving with a timer B tick. The bench provokes the first by loading timer B with zero and then driving the address-4 acknowledge read together with `t2Tick`. It also pairs a flag-register clear with a shifter event pulse. The flag must survive in both cases. For the second, it drives the address-5 write together with a tick, and the count must show the latch value with no flag raised.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int FLG_W  = BYTE_W - 1;

  // register addresses (behavioural map decoded by the bus control)
  localparam int RA_T1_CLO = 0;
  localparam int RA_T1_CHI = 1;
  localparam int RA_T1_LLO = 2;
  localparam int RA_T1_LHI = 3;
  localparam int RA_T2_CLO = 4;
  localparam int RA_T2_CHI = 5;
  localparam int RA_MODE   = 6;
  localparam int RA_FLAG   = 7;
  localparam int RA_ENAB   = 8;

  localparam int FLG_T1  = 6;
  localparam int FLG_T2  = 5;
  localparam int FLG_SH  = 2;
  localparam int MODE_T1_CONT = 6;

  localparam logic [FLG_W-1:0] FLAG_MASK =
    FLG_W'((1 << FLG_T1) | (1 << FLG_T2) | (1 << FLG_SH));

  // strobes from bus control into the datapath
  typedef struct packed {
    logic              t1LatLo;
    logic              t1LatHi;
    logic              t1LoadHi;
    logic              t1Ack;
    logic              t2LatLo;
    logic              t2LoadHi;
    logic              t2Ack;
    logic              modeWr;
    logic              flagWr;
    logic              enabWr;
    logic [BYTE_W-1:0] data;
  } strobes_t;

endpackage

// File: rtl/pdt_counter.sv
module pdt_counter
  import pdt_pkg::*;
#(
  parameter int W         = CNT_W,
  parameter bit RELOAD_OK = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         load,
  input  logic         contMode,
  input  logic [W-1:0] latchVal,
  output logic [W-1:0] count,
  output logic         expire
);

  logic armed;
  logic atZero;
  logic reloadNow;

  assign atZero    = (count == '0);
  assign reloadNow = RELOAD_OK && contMode;
  // a load in the same cycle overrides any tick
  assign expire    = tick && atZero && armed && !load;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '1;
      armed <= 1'b0;
    end else if (load) begin
      count <= latchVal;
      armed <= 1'b1;
    end else if (tick) begin
      if (atZero && reloadNow) count <= latchVal;
      else                     count <= count - 1'b1;
      if (atZero && !reloadNow) armed <= 1'b0;
    end
  end

endmodule

// File: rtl/pdt_datapath.sv
module pdt_datapath
  import pdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic              t1Tick,
  input  logic              t2Tick,
  input  logic              shiftEvent,
  output logic [CNT_W-1:0]  t1Count,
  output logic [CNT_W-1:0]  t1Latch,
  output logic [CNT_W-1:0]  t2Count,
  output logic [CNT_W-1:0]  t2Latch,
  output logic [BYTE_W-1:0] modeQ,
  output logic [FLG_W-1:0]  flagQ,
  output logic [FLG_W-1:0]  enabQ,
  output logic              irq
);

  localparam int NTMR = 2;

  logic [CNT_W-1:0] loadVal [NTMR];
  logic [CNT_W-1:0] cntArr  [NTMR];
  logic [NTMR-1:0]  loadArr;
  logic [NTMR-1:0]  tickArr;
  logic [NTMR-1:0]  expArr;

  // reload latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      t1Latch <= '1;
      t2Latch <= '1;
    end else begin
      if (stb.t1LatLo)                 t1Latch[BYTE_W-1:0]     <= stb.data;
      if (stb.t1LatHi || stb.t1LoadHi) t1Latch[CNT_W-1:BYTE_W] <= stb.data;
      if (stb.t2LatLo)                 t2Latch[BYTE_W-1:0]     <= stb.data;
      if (stb.t2LoadHi)                t2Latch[CNT_W-1:BYTE_W] <= stb.data;
    end
  end

  // the counter takes the freshly written high byte in the loading access
  assign loadVal[0] = stb.t1LoadHi ? {stb.data, t1Latch[BYTE_W-1:0]} : t1Latch;
  assign loadVal[1] = stb.t2LoadHi ? {stb.data, t2Latch[BYTE_W-1:0]} : t2Latch;
  assign loadArr    = {stb.t2LoadHi, stb.t1LoadHi};
  assign tickArr    = {t2Tick, t1Tick};

  // timer A may reload, timer B never does
  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    pdt_counter #(
      .W         (CNT_W),
      .RELOAD_OK (i == 0)
    ) u_cnt (
      .clk      (clk),
      .rstN     (rstN),
      .tick     (tickArr[i]),
      .load     (loadArr[i]),
      .contMode (modeQ[MODE_T1_CONT]),
      .latchVal (loadVal[i]),
      .count    (cntArr[i]),
      .expire   (expArr[i])
    );
  end

  assign t1Count = cntArr[0];
  assign t2Count = cntArr[1];

  // mode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           modeQ <= '0;
    else if (stb.modeWr) modeQ <= stb.data;
  end

  // flags: a set in the same cycle as a clear wins
  logic [FLG_W-1:0] setVec;
  logic [FLG_W-1:0] clrVec;

  always_comb begin
    setVec         = '0;
    setVec[FLG_T1] = expArr[0];
    setVec[FLG_T2] = expArr[1];
    setVec[FLG_SH] = shiftEvent;
    clrVec         = stb.flagWr ? stb.data[FLG_W-1:0] : '0;
    if (stb.t1Ack || stb.t1LoadHi) clrVec[FLG_T1] = 1'b1;
    if (stb.t2Ack || stb.t2LoadHi) clrVec[FLG_T2] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= ((flagQ & ~clrVec) | setVec) & FLAG_MASK;
  end

  // enables: top data bit picks set or clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabQ <= '0;
    end else if (stb.enabWr) begin
      if (stb.data[BYTE_W-1]) enabQ <= (enabQ |  stb.data[FLG_W-1:0]) & FLAG_MASK;
      else                    enabQ <= (enabQ & ~stb.data[FLG_W-1:0]) & FLAG_MASK;
    end
  end

  assign irq = |(flagQ & enabQ);

endmodule

// File: rtl/pdt_ctrl.sv
module pdt_ctrl
  import pdt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  input  logic [CNT_W-1:0]  t1Count,
  input  logic [CNT_W-1:0]  t1Latch,
  input  logic [CNT_W-1:0]  t2Count,
  input  logic [BYTE_W-1:0] modeQ,
  input  logic [FLG_W-1:0]  flagQ,
  input  logic [FLG_W-1:0]  enabQ,
  input  logic              irq,
  output strobes_t          stb,
  output logic [BYTE_W-1:0] busRdata
);

  logic wrEn;
  logic rdEn;

  assign wrEn = busSel && busWr;
  assign rdEn = busSel && !busWr;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ra);
    return a == ADDR_W'(ra);
  endfunction

  always_comb begin
    stb          = '0;
    stb.data     = busWdata;
    stb.t1LatLo  = wrEn && (hit(busAddr, RA_T1_CLO) || hit(busAddr, RA_T1_LLO));
    stb.t1LatHi  = wrEn && hit(busAddr, RA_T1_LHI);
    stb.t1LoadHi = wrEn && hit(busAddr, RA_T1_CHI);
    stb.t1Ack    = rdEn && hit(busAddr, RA_T1_CLO);
    stb.t2LatLo  = wrEn && hit(busAddr, RA_T2_CLO);
    stb.t2LoadHi = wrEn && hit(busAddr, RA_T2_CHI);
    stb.t2Ack    = rdEn && hit(busAddr, RA_T2_CLO);
    stb.modeWr   = wrEn && hit(busAddr, RA_MODE);
    stb.flagWr   = wrEn && hit(busAddr, RA_FLAG);
    stb.enabWr   = wrEn && hit(busAddr, RA_ENAB);
  end

  always_comb begin
    busRdata = '0;
    if (hit(busAddr, RA_T1_CLO)) busRdata = t1Count[BYTE_W-1:0];
    if (hit(busAddr, RA_T1_CHI)) busRdata = t1Count[CNT_W-1:BYTE_W];
    if (hit(busAddr, RA_T1_LLO)) busRdata = t1Latch[BYTE_W-1:0];
    if (hit(busAddr, RA_T1_LHI)) busRdata = t1Latch[CNT_W-1:BYTE_W];
    if (hit(busAddr, RA_T2_CLO)) busRdata = t2Count[BYTE_W-1:0];
    if (hit(busAddr, RA_T2_CHI)) busRdata = t2Count[CNT_W-1:BYTE_W];
    if (hit(busAddr, RA_MODE))   busRdata = modeQ;
    if (hit(busAddr, RA_FLAG))   busRdata = {irq, flagQ};
    if (hit(busAddr, RA_ENAB))   busRdata = {1'b1, enabQ};
  end

endmodule

// File: rtl/pdt_top.sv
module pdt_top
  import pdt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic              t1Tick,
  input  logic              t2Tick,
  input  logic              shiftEvent,
  output logic              irq
);

  strobes_t          stb;
  logic [CNT_W-1:0]  t1Count;
  logic [CNT_W-1:0]  t1Latch;
  logic [CNT_W-1:0]  t2Count;
  logic [CNT_W-1:0]  t2Latch;
  logic [BYTE_W-1:0] modeQ;
  logic [FLG_W-1:0]  flagQ;
  logic [FLG_W-1:0]  enabQ;

  pdt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .t1Count  (t1Count),
    .t1Latch  (t1Latch),
    .t2Count  (t2Count),
    .modeQ    (modeQ),
    .flagQ    (flagQ),
    .enabQ    (enabQ),
    .irq      (irq),
    .stb      (stb),
    .busRdata (busRdata)
  );

  pdt_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .t1Tick     (t1Tick),
    .t2Tick     (t2Tick),
    .shiftEvent (shiftEvent),
    .t1Count    (t1Count),
    .t1Latch    (t1Latch),
    .t2Count    (t2Count),
    .t2Latch    (t2Latch),
    .modeQ      (modeQ),
    .flagQ      (flagQ),
    .enabQ      (enabQ),
    .irq        (irq)
  );

endmodule

// File: rtl/pdt_checker.sv
module pdt_checker
  import pdt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BYTE_W-1:0] busWdata,
  input logic              t1Tick,
  input logic              t2Tick,
  input logic              shiftEvent,
  input logic              irq,
  input logic [CNT_W-1:0]  t1Count,
  input logic [CNT_W-1:0]  t1Latch,
  input logic [CNT_W-1:0]  t2Count,
  input logic [CNT_W-1:0]  t2Latch,
  input logic              modeCont,
  input logic [FLG_W-1:0]  flagQ,
  input logic [FLG_W-1:0]  enabQ
);

  logic wrT2Lo, wrT2Hi, rdT2Lo, wrFlag;
  assign wrT2Lo = busSel && busWr  && busAddr == ADDR_W'(RA_T2_CLO);
  assign wrT2Hi = busSel && busWr  && busAddr == ADDR_W'(RA_T2_CHI);
  assign rdT2Lo = busSel && !busWr && busAddr == ADDR_W'(RA_T2_CLO);
  assign wrFlag = busSel && busWr  && busAddr == ADDR_W'(RA_FLAG);

  // R2: low-byte write leaves the running count alone
  p_lo_keeps_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrT2Lo && !t2Tick |=> t2Count == $past(t2Count));

  // R3: high-byte write loads the full latch and drops the flag
  p_hi_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrT2Hi |=> (t2Count == {$past(busWdata), $past(t2Latch[BYTE_W-1:0])}) && !flagQ[FLG_T2]);

  // R4: a tick on a nonzero count steps down by one
  p_t2_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    t2Tick && !wrT2Hi && t2Count != '0 |=> t2Count == $past(t2Count) - 1'b1);

  // R6: acknowledge read clears the timer B flag when no expiry coincides
  p_t2_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdT2Lo && !(t2Tick && t2Count == '0) |=> !flagQ[FLG_T2]);

  // R8: periodic timer A reloads from its latch on the zero tick
  p_t1_reload_r8: assert property (@(posedge clk) disable iff (!rstN)
    t1Tick && t1Count == '0 && modeCont && !(busSel && busWr) |=> t1Count == $past(t1Latch));

  // R9: flag-register write clears the written ones when no source fires
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrFlag && !t1Tick && !t2Tick && !shiftEvent |=> (flagQ & $past(busWdata[FLG_W-1:0])) == '0);

  // R11: no enables, no request
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    enabQ == '0 |-> !irq);

endmodule

bind pdt_top pdt_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busSel     (busSel),
  .busWr      (busWr),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .t1Tick     (t1Tick),
  .t2Tick     (t2Tick),
  .shiftEvent (shiftEvent),
  .irq        (irq),
  .t1Count    (t1Count),
  .t1Latch    (t1Latch),
  .t2Count    (t2Count),
  .t2Latch    (t2Latch),
  .modeCont   (modeQ[6]),
  .flagQ      (flagQ),
  .enabQ      (enabQ)
);

// File: tb/sim_pdt_top.sv
`timescale 1ns/1ps
module sim_pdt_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       t1Tick = 1'b0;
  logic       t2Tick = 1'b0;
  logic       shiftEvent = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pdt_top #(.ADDR_W(4)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .t1Tick(t1Tick), .t2Tick(t2Tick), .shiftEvent(shiftEvent), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = 4'(a); busWdata = 8'(d);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = 4'(a);
    #1 d = int'(busRdata);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic tick1(input int n);
    @(negedge clk); t1Tick = 1'b1;
    repeat (n) @(negedge clk);
    t1Tick = 1'b0;
  endtask

  task automatic tick2(input int n);
    @(negedge clk); t2Tick = 1'b1;
    repeat (n) @(negedge clk);
    t2Tick = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    chk("R1 irq", int'(irq), 0);
    rd(1, v); chk("R1 t1 count hi", v, 8'hFF);
    rd(0, v); chk("R1 t1 count lo", v, 8'hFF);
    rd(2, v); chk("R1 t1 latch lo", v, 8'hFF);
    rd(3, v); chk("R1 t1 latch hi", v, 8'hFF);
    rd(7, v); chk("R1 flags", v, 8'h00);
    rd(8, v); chk("R1 enables", v, 8'h80);
    // timer B latch low byte is 0xFF from reset
    wr(5, 8'h12);
    rd(5, v); chk("R1 t2 latch hi load", v, 8'h12);
    rd(4, v); chk("R1 t2 latch lo reset", v, 8'hFF);
  endtask

  task automatic t_timerB();
    int v;
    wr(4, 8'h03);
    rd(5, v); chk("R2 count hi unchanged", v, 8'h12);
    wr(5, 8'h00);
    rd(4, v); chk("R3 loaded lo", v, 8'h03);
    tick1(5);
    rd(4, v); chk("R4 t1Tick ignored", v, 8'h03);
    tick2(3);
    rd(7, v); chk("R4 no flag before zero tick", v, 8'h00);
    rd(4, v); chk("R4 count at zero", v, 8'h00);
    tick2(1);
    rd(7, v); chk("R4 flag on zero tick", v, 8'h20);
    chk("R11 irq off while disabled", int'(irq), 0);
    wr(8, 8'hA0);
    chk("R11 irq on", int'(irq), 1);
    rd(7, v); chk("R9 flag bit7 mirrors irq", v, 8'hA0);
    rd(5, v); chk("R4 wrapped hi", v, 8'hFF);
    rd(7, v); chk("R6 hi read keeps flag", v, 8'hA0);
    rd(4, v); chk("R6 lo read value", v, 8'hFF);
    chk("R6 irq drops after lo read", int'(irq), 0);
    rd(7, v); chk("R6 flag cleared", v, 8'h00);
  endtask

  task automatic t_noReload();
    int v;
    wr(6, 8'h60);
    tick2(65536);
    rd(7, v); chk("R5 no second flag", v, 8'h00);
    rd(5, v); chk("R5 kept counting hi", v, 8'hFF);
    rd(4, v); chk("R5 kept counting lo", v, 8'hFF);
    wr(4, 8'h01);
    wr(5, 8'h00);
    tick2(2);
    rd(7, v); chk("R5 rearmed by hi write", v, 8'hA0);
    wr(7, 8'h20);
    rd(7, v); chk("R9 write-one clear", v, 8'h00);
  endtask

  task automatic t_timerAOneShot();
    int v;
    wr(6, 8'h00);
    wr(0, 8'h02);
    wr(1, 8'h00);
    tick1(3);
    rd(7, v); chk("R7 one-shot flag", v, 8'h40);
    rd(0, v); chk("R7 wrapped lo", v, 8'hFF);
    rd(7, v); chk("R7 lo read clears", v, 8'h00);
    tick1(3);
    rd(7, v); chk("R7 no second flag", v, 8'h00);
    rd(0, v); chk("R7 still counting", v, 8'hFC);
  endtask

  task automatic t_timerAPeriodic();
    int v;
    wr(6, 8'h40);
    wr(1, 8'h00);
    tick1(3);
    rd(7, v); chk("R8 first period flag", v, 8'h40);
    rd(1, v); chk("R8 reloaded hi", v, 8'h00);
    rd(0, v); chk("R8 reloaded lo", v, 8'h02);
    tick1(3);
    rd(7, v); chk("R8 second period flag", v, 8'h40);
    wr(7, 8'h40);
    wr(6, 8'h00);
  endtask

  task automatic t_enables();
    int v;
    @(negedge clk); shiftEvent = 1'b1;
    @(negedge clk); shiftEvent = 1'b0;
    rd(7, v); chk("R9 shifter flag", v, 8'h04);
    chk("R11 shifter not enabled", int'(irq), 0);
    wr(8, 8'h84);
    rd(8, v); chk("R10 set enables", v, 8'hA4);
    chk("R11 shifter enabled", int'(irq), 1);
    wr(8, 8'h04);
    rd(8, v); chk("R10 clear enables", v, 8'hA0);
    chk("R11 irq off", int'(irq), 0);
    wr(7, 8'h04);
    rd(7, v); chk("R9 shifter cleared", v, 8'h00);
  endtask

  task automatic t_collide();
    int v;
    wr(4, 8'h00);
    wr(5, 8'h00);
    // acknowledge read together with the expiring tick
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = 4'd4; t2Tick = 1'b1;
    @(negedge clk);
    busSel = 1'b0; t2Tick = 1'b0;
    rd(7, v); chk("R12 set beats ack read", v, 8'hA0);
    // flag-register clear together with a shifter event
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = 4'd7; busWdata = 8'h04; shiftEvent = 1'b1;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; shiftEvent = 1'b0;
    rd(7, v); chk("R12 set beats flag write", v, 8'hA4);
    wr(7, 8'h24);
    // load together with a tick: load wins, flag cleared, no set
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = 4'd5; busWdata = 8'h00; t2Tick = 1'b1;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; t2Tick = 1'b0;
    rd(5, v); chk("R3 load beats tick hi", v, 8'h00);
    rd(7, v); chk("R3 no flag on load cycle", v, 8'h00);
    rd(4, v); chk("R3 load beats tick lo", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_timerB();
    t_noReload();
    t_timerAOneShot();
    t_timerAPeriodic();
    t_enables();
    t_collide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule